// File: doc/BRIEF.md
# UART Receive Release Controller

This block sits between a UART receive FIFO and a USB bulk-IN endpoint and decides, for every bulk-IN request, whether buffered receive bytes may go to the host now. It watches the FIFO fill count, a strobe for each byte the receiver stores, a bit-time tick and the programmed baud rate. Each request gets a one-cycle answer on the next clock: either a grant with a transfer length, or a not-ready indication.

In normal operation bytes are held back until a full packet has built up, or until the line has been idle for three character times. A low-latency mode answers every request with whatever the FIFO holds. That mode is switched on by itself when the baud rate is slow. The packet threshold is 64 bytes, or 63 bytes when a select bit is set. That bit is also set by itself when a communications-class command arrives.

Two one-bit control registers are reachable through a small write port and a combinational read port. Address 0 is the packet-size register and address 1 is the latency register. In both, bit 0 is the only live bit.

Top module: `rx_release_ctrl`

## Requirements
- R1: The packet threshold is 64 when bit 0 of register 0 is 0 and 63 when it is 1. A grant carries length min(fifo_cnt, threshold). With low latency off, a request is granted whenever fifo_cnt is at or above the threshold.
- R2: A class_cmd pulse sets bit 0 of register 0 to 1 on the next edge. A software write of 0 to that register in the same cycle loses. A software write at any other time takes effect.
- R3: A request held for one cycle gets exactly one of in_grant or in_nak on the next cycle, for one cycle. With low latency off, below the threshold and with no idle timeout, the answer is in_nak and in_len is 0.
- R4: With bit 0 of register 1 set, every request is granted whatever fifo_cnt is, including zero (length 0).
- R5: A baud_upd with baud_rate below 46921 sets bit 0 of register 1. Software writes of 0 to it are then ignored until a baud_upd at or above 46921. After that update the register keeps its value and software writes take effect again.
- R6: Bits 7:1 of both registers read as 0 whatever was written.
- R7: The idle timeout expires after 3*(2 + data_w + par_en + stop2) bit_tick pulses with no received byte while the FIFO is non-empty. After expiry, a request is granted with length min(fifo_cnt, threshold).
- R8: rx_byte restarts the idle count, and it wins over a bit_tick in the same cycle. The count does not advance while fifo_cnt is 0. Expiry, once reached, holds through later bytes until fifo_cnt is 0.
- R9: After reset both registers read 0, in_grant and in_nak are low, and the idle timer is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 packet size, 1 latency |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| class_cmd | input | 1 | Class command received pulse |
| baud_upd | input | 1 | Baud rate changed pulse |
| baud_rate | input | 24 | Programmed baud rate in bits per second |
| data_w | input | 4 | Data bits per character (7 to 9) |
| par_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits |
| fifo_cnt | input | 7 | Bytes currently in the receive FIFO |
| rx_byte | input | 1 | Pulse per byte written into the FIFO |
| bit_tick | input | 1 | One pulse per bit time |
| in_req | input | 1 | Bulk-IN request pulse |
| in_grant | output | 1 | Request granted (one cycle) |
| in_nak | output | 1 | Request not ready (one cycle) |
| in_len | output | 7 | Granted transfer length |

## Verification
Two pairs of functions can collide in one cycle, and both are provoked on purpose. First, a received-byte strobe is driven together with the bit tick that would have completed the idle count. The bench then checks that a further full-minus-one run of ticks still gives not-ready, so the restart won. Second, a class command is driven in the same cycle as a software write of 0 to the packet register, and a baud update below the boundary in the same cycle as a write of 0 to the latency register. Both registers are then read back as 1, and the effective threshold is confirmed through granted lengths.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // bits in one character: start + data + optional parity + one or two stops
  function automatic logic [7:0] frame_bits(input logic [3:0] dw, input logic par,
                                            input logic two_stop);
    return 8'd2 + 8'(dw) + 8'(par) + 8'(two_stop);
  endfunction

  // idle timeout measured in bit ticks: three characters
  function automatic logic [7:0] idle_limit(input logic [3:0] dw, input logic par,
                                            input logic two_stop);
    return 8'd3 * frame_bits(dw, par, two_stop);
  endfunction

  function automatic logic [7:0] pkt_thresh(input logic short_pkt);
    return short_pkt ? 8'd63 : 8'd64;
  endfunction
endpackage

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs #(
  parameter int BAUD_W    = 24,
  parameter int BAUD_EDGE = 46921
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [7:0]        wdata,
  input  logic              class_cmd,
  input  logic              baud_upd,
  input  logic [BAUD_W-1:0] baud_rate,
  output logic [7:0]        rdata,
  output logic              pkt_sel,
  output logic              ll_en
);
  logic slow_q, slow_nx;
  logic pkt_q, ll_q;

  assign slow_nx = baud_upd ? (baud_rate < BAUD_W'(BAUD_EDGE)) : slow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      pkt_q  <= 1'b0;
      ll_q   <= 1'b0;
    end else begin
      slow_q <= slow_nx;
      if (class_cmd)
        pkt_q <= 1'b1;
      else if (wr && !addr)
        pkt_q <= wdata[0];
      if (wr && addr)
        ll_q <= wdata[0] | slow_nx;
      else if (slow_nx)
        ll_q <= 1'b1;
    end
  end

  assign pkt_sel = pkt_q;
  assign ll_en   = ll_q;
  assign rdata   = {7'd0, addr ? ll_q : pkt_q};
endmodule

// File: rtl/rxr_idle_timer.sv
module rxr_idle_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_empty,
  input  logic             rx_byte,
  input  logic             bit_tick,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q;
  logic             exp_q;
  logic             hit;

  assign hit = (cnt_q + TMR_W'(1)) >= limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (fifo_empty) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (rx_byte) begin
      cnt_q <= '0;
    end else if (bit_tick && !exp_q) begin
      if (hit) begin
        cnt_q <= '0;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + TMR_W'(1);
      end
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/rxr_release_arb.sv
module rxr_release_arb #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_req,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic [CNT_W-1:0] thresh,
  input  logic             ll_en,
  input  logic             expired,
  output logic             release_ok,
  output logic             in_grant,
  output logic             in_nak,
  output logic [CNT_W-1:0] in_len
);
  logic [CNT_W-1:0] len_c;

  assign release_ok = ll_en || (fifo_cnt >= thresh) || (expired && fifo_cnt != '0);
  assign len_c      = (fifo_cnt < thresh) ? fifo_cnt : thresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_grant <= 1'b0;
      in_nak   <= 1'b0;
      in_len   <= '0;
    end else begin
      in_grant <= in_req && release_ok;
      in_nak   <= in_req && !release_ok;
      in_len   <= (in_req && release_ok) ? len_c : '0;
    end
  end
endmodule

// File: rtl/rx_release_ctrl.sv
module rx_release_ctrl #(
  parameter int CNT_W     = 7,
  parameter int BAUD_W    = 24,
  parameter int BAUD_EDGE = 46921,
  parameter int TMR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              class_cmd,
  input  logic              baud_upd,
  input  logic [BAUD_W-1:0] baud_rate,
  input  logic [3:0]        data_w,
  input  logic              par_en,
  input  logic              stop2,
  input  logic [CNT_W-1:0]  fifo_cnt,
  input  logic              rx_byte,
  input  logic              bit_tick,
  input  logic              in_req,
  output logic              in_grant,
  output logic              in_nak,
  output logic [CNT_W-1:0]  in_len
);
  import rxr_pkg::*;

  // named internal events, visible to the bound checker
  logic             pkt_sel;
  logic             ll_en;
  logic             idle_expired;
  logic             release_ok;
  logic [CNT_W-1:0] thresh;
  logic [TMR_W-1:0] limit;

  assign thresh = CNT_W'(pkt_thresh(pkt_sel));
  assign limit  = TMR_W'(idle_limit(data_w, par_en, stop2));

  rxr_cfg_regs #(.BAUD_W(BAUD_W), .BAUD_EDGE(BAUD_EDGE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .class_cmd(class_cmd), .baud_upd(baud_upd), .baud_rate(baud_rate),
    .rdata(cfg_rdata), .pkt_sel(pkt_sel), .ll_en(ll_en)
  );

  rxr_idle_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_cnt == '0), .rx_byte(rx_byte),
    .bit_tick(bit_tick), .limit(limit), .expired(idle_expired)
  );

  rxr_release_arb #(.CNT_W(CNT_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .fifo_cnt(fifo_cnt), .thresh(thresh),
    .ll_en(ll_en), .expired(idle_expired), .release_ok(release_ok),
    .in_grant(in_grant), .in_nak(in_nak), .in_len(in_len)
  );
endmodule

// File: rtl/rx_release_chk.sv
module rx_release_chk #(
  parameter int CNT_W     = 7,
  parameter int BAUD_W    = 24,
  parameter int BAUD_EDGE = 46921
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_req,
  input logic              in_grant,
  input logic              in_nak,
  input logic [CNT_W-1:0]  in_len,
  input logic              class_cmd,
  input logic              baud_upd,
  input logic [BAUD_W-1:0] baud_rate,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic [7:0]        cfg_rdata,
  input logic              pkt_sel,
  input logic              ll_en,
  input logic              idle_expired
);
  assert_one_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_grant && in_nak));
  assert_reply_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_grant || in_nak) |-> $past(in_req));
  assert_len_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_grant |-> (in_len <= CNT_W'(64) && in_len <= $past(fifo_cnt)));
  assert_class_force_R2: assert property (@(posedge clk) disable iff (!rst_n)
    class_cmd |=> pkt_sel);
  assert_slow_baud_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_upd && baud_rate < BAUD_W'(BAUD_EDGE)) |=> ll_en);
  assert_low_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && ll_en) |=> in_grant);
  assert_resv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:1] == 7'd0);
  assert_expiry_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_expired) |-> ($past(fifo_cnt) == '0));
endmodule

bind rx_release_ctrl rx_release_chk #(.CNT_W(CNT_W), .BAUD_W(BAUD_W), .BAUD_EDGE(BAUD_EDGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_grant(in_grant), .in_nak(in_nak),
  .in_len(in_len), .class_cmd(class_cmd), .baud_upd(baud_upd), .baud_rate(baud_rate),
  .fifo_cnt(fifo_cnt), .cfg_rdata(cfg_rdata), .pkt_sel(pkt_sel), .ll_en(ll_en),
  .idle_expired(idle_expired)
);

// File: tb/sim_rx_release_ctrl.sv
`timescale 1ns/1ps
module sim_rx_release_ctrl;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic class_cmd = 0, baud_upd = 0;
  logic [23:0] baud_rate = 0;
  logic [3:0] data_w = 4'd8;
  logic par_en = 0, stop2 = 0;
  logic [6:0] fifo_cnt = 0;
  logic rx_byte = 0, bit_tick = 0, in_req = 0;
  logic in_grant, in_nak;
  logic [6:0] in_len;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_release_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .class_cmd(class_cmd), .baud_upd(baud_upd), .baud_rate(baud_rate),
    .data_w(data_w), .par_en(par_en), .stop2(stop2), .fifo_cnt(fifo_cnt), .rx_byte(rx_byte),
    .bit_tick(bit_tick), .in_req(in_req), .in_grant(in_grant), .in_nak(in_nak), .in_len(in_len)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0; cfg_wdata = 0;
  endtask

  task automatic rd(input bit a, output logic [7:0] d);
    cfg_addr = a; #0.5; d = cfg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_byte = 1;
    @(negedge clk); rx_byte = 0;
  endtask

  // request and judge: exp_g=1 means grant with exp_len, else one-cycle not-ready
  task automatic ask(input bit exp_g, input int exp_len, input string req);
    @(negedge clk); in_req = 1;
    @(negedge clk); in_req = 0;
    chk(in_grant == exp_g && in_nak == !exp_g, req, {in_grant, in_nak}, {exp_g, !exp_g});
    if (exp_g) chk(int'(in_len) == exp_len, req, in_len, exp_len);
    else       chk(in_len == 0, req, in_len, 0);
    @(negedge clk);
    chk(!in_grant && !in_nak, req, {in_grant, in_nak}, 0);
  endtask

  task automatic set_baud(input int b);
    @(negedge clk); baud_upd = 1; baud_rate = 24'(b);
    @(negedge clk); baud_upd = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int thr, lim;
    repeat (3) @(negedge clk);
    // R9: reset state
    rd(0, d); chk(d == 0, "R9 reg0", d, 0);
    rd(1, d); chk(d == 0, "R9 reg1", d, 0);
    chk(!in_grant && !in_nak, "R9 outputs", {in_grant, in_nak}, 0);
    rst_n = 1;
    @(negedge clk);
    // idle timer clear after reset: data present, no ticks -> not ready
    fifo_cnt = 7'd5;
    ask(0, 0, "R9 timer clear");
    fifo_cnt = 0;

    // R6: reserved bits
    wr(0, 8'hFF); rd(0, d); chk(d == 8'h01, "R6 reg0", d, 1);
    wr(1, 8'hFE); rd(1, d); chk(d == 8'h00, "R6 reg1", d, 0);
    wr(1, 8'hFF); rd(1, d); chk(d == 8'h01, "R6 reg1 set", d, 1);
    wr(0, 8'h00); wr(1, 8'h00);

    set_baud(115200);
    // R1/R3: sweep count under both thresholds, low latency off, no timeout
    for (int s = 0; s < 2; s++) begin
      wr(0, 8'(s));
      thr = s ? 63 : 64;
      for (int c = 0; c <= 90; c++) begin
        @(negedge clk); fifo_cnt = 7'(c);
        ask(c >= thr, (c < thr) ? c : thr, c >= thr ? "R1 sweep" : "R3 sweep");
      end
    end

    // R2: class command wins against a same-cycle write of 0
    wr(0, 8'h00);
    @(negedge clk); class_cmd = 1; cfg_wr = 1; cfg_addr = 0; cfg_wdata = 0;
    @(negedge clk); class_cmd = 0; cfg_wr = 0;
    rd(0, d); chk(d == 8'h01, "R2 force", d, 1);
    fifo_cnt = 7'd63; ask(1, 63, "R2 threshold 63");
    wr(0, 8'h00); rd(0, d); chk(d == 0, "R2 software clear", d, 0);
    ask(0, 0, "R2 threshold back to 64");

    // R4: low latency sweep, any count
    wr(1, 8'h01);
    for (int c = 0; c <= 70; c++) begin
      @(negedge clk); fifo_cnt = 7'(c);
      ask(1, (c < 64) ? c : 64, "R4 sweep");
    end

    // R5: baud-driven auto set
    wr(1, 8'h00); rd(1, d); chk(d == 0, "R5 fast write 0", d, 0);
    set_baud(46920); rd(1, d); chk(d == 1, "R5 slow sets", d, 1);
    wr(1, 8'h00); rd(1, d); chk(d == 1, "R5 write ignored while slow", d, 1);
    fifo_cnt = 7'd3; ask(1, 3, "R5 low latency effective");
    set_baud(46921); rd(1, d); chk(d == 1, "R5 keeps at boundary", d, 1);
    wr(1, 8'h00); rd(1, d); chk(d == 0, "R5 write takes effect", d, 0);
    // same-cycle slow update and write of 0
    @(negedge clk); baud_upd = 1; baud_rate = 24'd9600; cfg_wr = 1; cfg_addr = 1; cfg_wdata = 0;
    @(negedge clk); baud_upd = 0; cfg_wr = 0;
    rd(1, d); chk(d == 1, "R5 collision", d, 1);
    set_baud(921600); wr(1, 8'h00);

    // R7: idle timeout over all frame configurations
    for (int dwi = 7; dwi <= 9; dwi++)
      for (int p = 0; p < 2; p++)
        for (int s2 = 0; s2 < 2; s2++) begin
          @(negedge clk); fifo_cnt = 0;
          data_w = 4'(dwi); par_en = p[0]; stop2 = s2[0];
          lim = 3 * (2 + dwi + p + s2);
          @(negedge clk); fifo_cnt = 7'd2;
          pulse_rx();
          ticks(lim - 1);
          ask(0, 0, "R7 before limit");
          ticks(1);
          ask(1, 2, "R7 at limit");
        end

    // R8: restart on byte, collision with tick, hold, empty-freeze
    data_w = 8; par_en = 0; stop2 = 0; lim = 30;
    @(negedge clk); fifo_cnt = 0;
    @(negedge clk); fifo_cnt = 7'd4;
    pulse_rx(); ticks(lim - 1);
    @(negedge clk); rx_byte = 1; bit_tick = 1;
    @(negedge clk); rx_byte = 0; bit_tick = 0;
    ticks(lim - 1);
    ask(0, 0, "R8 byte beats tick");
    ticks(1);
    ask(1, 4, "R8 expiry after restart");
    fifo_cnt = 7'd5; pulse_rx();
    ask(1, 5, "R8 expiry holds through byte");
    @(negedge clk); fifo_cnt = 0;
    ticks(lim + 5);
    @(negedge clk); fifo_cnt = 7'd6;
    ask(0, 0, "R8 no count while empty");
    ticks(lim - 1);
    ask(0, 0, "R8 fresh count");
    ticks(1);
    ask(1, 6, "R8 fresh expiry");
    fifo_cnt = 7'd70;
    ask(1, 64, "R7 expiry length capped");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule